// File: doc/BRIEF.md
# Shared Communication Memory Access Controller

This block lets six DMA requesters share one external communication memory. A receive and a transmit requester exist for each of three link channels. Each requester owns an address generator. Arming a generator loads a start and an end address, and its current address is copied from the start. While the requester's FIFO side reports it ready, the generator asks for memory cycles. It stops asking once its current address reaches the end address. A fair rotating arbiter picks one requester per access. The chosen address then goes out together with a read strobe (transmit) or a write strobe (receive) and one of two active-low bank selects.

The memory is dual-ported and may be shared with a second, identical controller. The two controllers coordinate without an external arbiter. Each one raises an occupied output around its own access and holds off while the peer's occupied signal is high. A strap input makes one controller the master, which wins when both want the memory in the same cycle. The length of the occupied pulse and the bank split point are programmable inputs. When a transmit requester completes its last word, a per-channel completion pulse tells the link side to append an end-of-packet marker.

Top module: `shmem_dma_arb`

## Requirements
- R1: While `rst_n` is low and after its release: `mem_cs_n` = 2'b11, `mem_rd_n` = `mem_wr_n` = 1, `grant` = 0, `tx_done` = 0, `occ_out` = 0, and every current address reads 0.
- R2: A pulse on `arm_en` with `arm_sel` = i sets requester i's end address to `arm_end` and its current address to `arm_start`. Each granted access uses the current address and then increments it. A requester is active only while `req_rdy[i]` is high and its current address differs from its end address. Words start..end-1 are therefore moved, and a later arm restarts the requester.
- R3: Requester indices 0..2 are receive channels 0..2 and indices 3..5 are transmit channels 0..2. The arbiter searches upward, with wrap-around, from the index after the last granted one. After reset, index 0 is searched first.
- R4: An access appears on the clock edge after the grant decision and lasts one cycle. `mem_addr` is the requester's current address. A receive requester drives `mem_wr_n` low, a transmit requester drives `mem_rd_n` low, and the two are never low together.
- R5: During an access, `mem_cs_n[0]` is low when `mem_addr[15:8]` <= `cs0_top`; otherwise `mem_cs_n[1]` is low. Exactly one of them is low.
- R6: `tx_done[k]` is high in the same cycle as the read strobe of the access that brings transmit channel k's current address up to its end address. It is low at all other times.
- R7: With `occ_len` = N >= 2, every access raises `occ_out` for exactly N-1 consecutive cycles. The next access decision comes no earlier than N cycles after the previous one.
- R8: While `occ_in` is high, no new access is decided. In slave mode (`is_master` = 0), `occ_out` rises in the strobe cycle. In master mode it rises already in the decision cycle, one cycle before the strobe, so that a slave deciding in the same cycle defers.
- R9: `grant` is one-hot during an access, marks the served requester, and is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_en | input | 1 | Load start/end into the selected generator |
| arm_sel | input | 3 | Requester index to arm |
| arm_start | input | 16 | Start address for arming |
| arm_end | input | 16 | End address (exclusive) for arming |
| req_rdy | input | 6 | Per-requester FIFO readiness |
| cs0_top | input | 8 | Highest upper address byte mapped to bank 0 |
| occ_len | input | 8 | Occupied pulse length parameter N |
| is_master | input | 1 | Strap: 1 master, 0 slave |
| occ_in | input | 1 | Peer controller occupied |
| occ_out | output | 1 | This controller occupied |
| mem_addr | output | 16 | Memory address |
| mem_cs_n | output | 2 | Bank selects, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_wr_n | output | 1 | Write strobe, active low |
| grant | output | 6 | One-hot served requester during an access |
| tx_done | output | 3 | Per transmit channel completion pulse |
| cur_addr | output | 96 | Current addresses, requester i in bits 16*i+15:16*i |

## Verification
The assertions rely on three assumptions about the inputs. `occ_len` and the strap only change while the block is idle. A requester is never armed in the same cycle in which it is granted. `occ_in` comes from a peer that follows the same handshake. The bench therefore arms generators while `req_rdy` is low or the requester is idle. It changes the pulse length, strap and bank boundary only between scenarios, after all expected accesses have drained. It drives `occ_in` as a level that a peer would hold, which puts deferral and release in well-defined cycles.

// File: rtl/shmem_arb_pkg.sv
package shmem_arb_pkg;
  // kind of memory cycle held in the output stage
  typedef enum logic [1:0] {
    XFER_IDLE = 2'd0,
    XFER_WR   = 2'd1,
    XFER_RD   = 2'd2
  } xfer_e;
endpackage

// File: rtl/shmem_addr_gen.sv
module shmem_addr_gen #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic [AW-1:0] arm_start,
  input  logic [AW-1:0] arm_end,
  input  logic          step,
  output logic [AW-1:0] cur,
  output logic          pending,
  output logic          last
);
  logic [AW-1:0] cur_q, cur_d, end_q, end_d;

  always_comb begin
    cur_d = cur_q;
    end_d = end_q;
    if (arm) begin
      cur_d = arm_start;
      end_d = arm_end;
    end else if (step) begin
      cur_d = cur_q + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      end_q <= '0;
    end else begin
      cur_q <= cur_d;
      end_q <= end_d;
    end
  end

  assign cur     = cur_q;
  assign pending = (cur_q != end_q);
  assign last    = ((cur_q + AW'(1)) == end_q);

  // the arbiter must never serve a generator that has run out
  assert_step_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> pending);
endmodule

// File: rtl/shmem_rr_arb.sv
module shmem_rr_arb #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         advance,
  output logic [N-1:0] gnt
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] last_q, last_d, pick;
  logic          found;
  int            j;

  always_comb begin
    gnt   = '0;
    pick  = last_q;
    found = 1'b0;
    j     = 0;
    for (int k = 1; k <= N; k++) begin
      j = (int'(last_q) + k) % N;
      if (!found && req[j]) begin
        found  = 1'b1;
        gnt[j] = 1'b1;
        pick   = IW'(j);
      end
    end
  end

  always_comb begin
    last_d = last_q;
    if (advance && found) last_d = pick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= IW'(N - 1);
    else        last_q <= last_d;
  end

  assert_grant_when_asked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> $onehot(gnt));
  assert_no_grant_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(|req) |-> (gnt == '0));
endmodule

// File: rtl/shmem_peer_hs.sv
module shmem_peer_hs #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          is_master,
  input  logic          occ_in,
  input  logic [CW-1:0] occ_len,
  input  logic          want,
  output logic          start,
  output logic          occ_out
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          idle;

  assign idle  = (cnt_q == '0);
  assign start = want && idle && !occ_in;

  always_comb begin
    cnt_d = cnt_q;
    if (start)      cnt_d = (occ_len == '0) ? '0 : occ_len - CW'(1);
    else if (!idle) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // master announces in the decision cycle, slave from the strobe cycle on
  assign occ_out = is_master ? (start || (cnt_q > CW'(1))) : !idle;

  assert_defer_on_peer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    occ_in |-> !start);
endmodule

// File: rtl/shmem_dma_arb.sv
module shmem_dma_arb
  import shmem_arb_pkg::*;
#(
  parameter int NCH = 3,
  parameter int AW  = 16,
  parameter int BW  = 8,
  parameter int CW  = 8,
  localparam int NREQ = 2 * NCH,
  localparam int SW   = $clog2(NREQ)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 arm_en,
  input  logic [SW-1:0]        arm_sel,
  input  logic [AW-1:0]        arm_start,
  input  logic [AW-1:0]        arm_end,
  input  logic [NREQ-1:0]      req_rdy,
  input  logic [BW-1:0]        cs0_top,
  input  logic [CW-1:0]        occ_len,
  input  logic                 is_master,
  input  logic                 occ_in,
  output logic                 occ_out,
  output logic [AW-1:0]        mem_addr,
  output logic [1:0]           mem_cs_n,
  output logic                 mem_rd_n,
  output logic                 mem_wr_n,
  output logic [NREQ-1:0]      grant,
  output logic [NCH-1:0]       tx_done,
  output logic [NREQ*AW-1:0]   cur_addr
);
  logic [AW-1:0]   cur_v [NREQ];
  logic [NREQ-1:0] pending_v, last_v, arm_v, step_v, fin_v, active, gnt_c;
  logic            start, is_tx;
  logic [AW-1:0]   sel_addr;

  // per-requester address generators
  for (genvar i = 0; i < NREQ; i++) begin : g_gen
    assign arm_v[i] = arm_en && (arm_sel == SW'(i));
    shmem_addr_gen #(.AW(AW)) u_gen (
      .clk(clk), .rst_n(rst_n), .arm(arm_v[i]),
      .arm_start(arm_start), .arm_end(arm_end), .step(step_v[i]),
      .cur(cur_v[i]), .pending(pending_v[i]), .last(last_v[i])
    );
    assign cur_addr[i*AW +: AW] = cur_v[i];
    assign active[i] = req_rdy[i] && pending_v[i];
    assign step_v[i] = start && gnt_c[i];
    assign fin_v[i]  = step_v[i] && last_v[i];

    assert_finish_stops_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fin_v[i] && !arm_v[i]) |=> !pending_v[i]);
  end

  shmem_rr_arb #(.N(NREQ)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(active), .advance(start), .gnt(gnt_c)
  );

  shmem_peer_hs #(.CW(CW)) u_hs (
    .clk(clk), .rst_n(rst_n), .is_master(is_master), .occ_in(occ_in),
    .occ_len(occ_len), .want(|active), .start(start), .occ_out(occ_out)
  );

  always_comb begin
    sel_addr = '0;
    for (int i = 0; i < NREQ; i++)
      if (gnt_c[i]) sel_addr = sel_addr | cur_v[i];
  end
  assign is_tx = |gnt_c[NREQ-1:NCH];

  // output stage: next state
  logic [AW-1:0]   addr_q, addr_d;
  logic [1:0]      cs_n_q, cs_n_d;
  xfer_e           xfer_q, xfer_d;
  logic [NREQ-1:0] gnt_q, gnt_d;
  logic [NCH-1:0]  done_q, done_d;

  always_comb begin
    addr_d = addr_q;
    cs_n_d = 2'b11;
    xfer_d = XFER_IDLE;
    gnt_d  = '0;
    done_d = '0;
    if (start) begin
      addr_d = sel_addr;
      cs_n_d = (sel_addr[AW-1 -: BW] <= cs0_top) ? 2'b10 : 2'b01;
      xfer_d = is_tx ? XFER_RD : XFER_WR;
      gnt_d  = gnt_c;
      done_d = fin_v[NREQ-1:NCH];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cs_n_q <= 2'b11;
      xfer_q <= XFER_IDLE;
      gnt_q  <= '0;
      done_q <= '0;
    end else begin
      addr_q <= addr_d;
      cs_n_q <= cs_n_d;
      xfer_q <= xfer_d;
      gnt_q  <= gnt_d;
      done_q <= done_d;
    end
  end

  assign mem_addr = addr_q;
  assign mem_cs_n = cs_n_q;
  assign mem_rd_n = (xfer_q != XFER_RD);
  assign mem_wr_n = (xfer_q != XFER_WR);
  assign grant    = gnt_q;
  assign tx_done  = done_q;

  logic strobe;
  assign strobe = !mem_rd_n || !mem_wr_n;

  assert_rw_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_rd_n && !mem_wr_n));
  assert_one_bank_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> ($countones(~mem_cs_n) == 1));
  assert_bank_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |-> (mem_cs_n == 2'b11));
  assert_grant_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> $onehot(grant));
  assert_grant_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |-> (grant == '0));
  assert_done_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|tx_done) |-> !mem_rd_n);
  assert_slave_defer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_master && occ_in) |=> !strobe);
  assert_occ_covers_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && $stable(occ_len) && occ_len >= CW'(3)) |-> occ_out);
endmodule

// File: tb/shmem_dma_arb_bench.sv
module shmem_dma_arb_bench;
  logic        clk, rst_n;
  logic        arm_en;
  logic [2:0]  arm_sel;
  logic [15:0] arm_start, arm_end;
  logic [5:0]  req_rdy;
  logic [7:0]  cs0_top, occ_len;
  logic        is_master, occ_in, occ_out;
  logic [15:0] mem_addr;
  logic [1:0]  mem_cs_n;
  logic        mem_rd_n, mem_wr_n;
  logic [5:0]  grant;
  logic [2:0]  tx_done;
  logic [95:0] cur_addr;

  shmem_dma_arb u_shmem_dma_arb (
    .clk(clk), .rst_n(rst_n), .arm_en(arm_en), .arm_sel(arm_sel),
    .arm_start(arm_start), .arm_end(arm_end), .req_rdy(req_rdy),
    .cs0_top(cs0_top), .occ_len(occ_len), .is_master(is_master),
    .occ_in(occ_in), .occ_out(occ_out), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
    .grant(grant), .tx_done(tx_done), .cur_addr(cur_addr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic [15:0] addr;
    logic [1:0]  cs_n;
    logic        rd_n;
    logic        wr_n;
    logic [5:0]  gnt;
    logic [2:0]  done;
  } acc_t;

  acc_t exp_q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   ended  = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic report();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // expected item: bank from R5, strobe kind from R3/R4, done from R6
  task automatic push_acc(input int idx, input logic [15:0] a, input logic [2:0] dn);
    acc_t e;
    e.addr = a;
    e.cs_n = (a[15:8] <= cs0_top) ? 2'b10 : 2'b01;
    e.rd_n = (idx >= 3) ? 1'b0 : 1'b1;
    e.wr_n = (idx >= 3) ? 1'b1 : 1'b0;
    e.gnt  = 6'(1) << idx;
    e.done = dn;
    exp_q.push_back(e);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !ended && (!mem_rd_n || !mem_wr_n)) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected access addr", 32'(mem_addr), 32'hffff);
      end else begin
        acc_t e;
        e = exp_q.pop_front();
        chk(mem_addr == e.addr, "R2 R3 access address", 32'(mem_addr), 32'(e.addr));
        chk(mem_cs_n == e.cs_n, "R5 bank select", 32'(mem_cs_n), 32'(e.cs_n));
        chk({mem_rd_n, mem_wr_n} == {e.rd_n, e.wr_n}, "R4 strobe kind",
            32'({mem_rd_n, mem_wr_n}), 32'({e.rd_n, e.wr_n}));
        chk(grant == e.gnt, "R9 grant", 32'(grant), 32'(e.gnt));
        chk(tx_done == e.done, "R6 tx_done", 32'(tx_done), 32'(e.done));
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic arm(input int idx, input logic [15:0] s, input logic [15:0] e);
    arm_en = 1'b1; arm_sel = 3'(idx); arm_start = s; arm_end = e;
    cyc(1);
    arm_en = 1'b0;
  endtask

  task automatic drain(input string tag);
    int w = 0;
    while (exp_q.size() != 0 && w < 300) begin
      @(posedge clk);
      w++;
    end
    #1;
    chk(exp_q.size() == 0, tag, 32'(exp_q.size()), 0);
    cyc(6);
  endtask

  function automatic logic [15:0] cur_of(input int idx);
    return cur_addr[idx*16 +: 16];
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      report();
    end
  end

  initial begin
    rst_n = 1'b0; arm_en = 1'b0; arm_sel = '0; arm_start = '0; arm_end = '0;
    req_rdy = '0; cs0_top = 8'hff; occ_len = 8'd2; is_master = 1'b0; occ_in = 1'b0;
    repeat (3) @(negedge clk);
    chk(mem_cs_n == 2'b11, "R1 cs idle in reset", 32'(mem_cs_n), 3);
    chk(mem_rd_n && mem_wr_n, "R1 strobes idle in reset", 32'({mem_rd_n, mem_wr_n}), 3);
    chk(grant == 0 && tx_done == 0, "R1 grant/done zero", 32'({grant, tx_done}), 0);
    chk(occ_out == 1'b0, "R1 occ_out low", 32'(occ_out), 0);
    chk(cur_addr == '0, "R1 current addresses zero", 32'(cur_addr[31:0]), 0);
    cyc(1);
    rst_n = 1'b1;
    cyc(2);

    // single receive requester, R2
    arm(0, 16'h0010, 16'h0013);
    chk(cur_of(0) == 16'h0010, "R2 arm loads current", 32'(cur_of(0)), 32'h10);
    push_acc(0, 16'h0010, 3'b000);
    push_acc(0, 16'h0011, 3'b000);
    push_acc(0, 16'h0012, 3'b000);
    req_rdy = 6'b000001;
    drain("R2 single requester drained");
    chk(cur_of(0) == 16'h0013, "R2 stops at end", 32'(cur_of(0)), 32'h13);
    req_rdy = '0;

    // re-arm, R2
    arm(0, 16'h0020, 16'h0021);
    push_acc(0, 16'h0020, 3'b000);
    req_rdy = 6'b000001;
    drain("R2 re-arm drained");
    req_rdy = '0;

    // rotation over three requesters, last granted was 0, R3 R5 R6
    cs0_top = 8'h7f;
    cyc(1);
    arm(0, 16'h0100, 16'h0102);
    arm(4, 16'h8000, 16'h8002);
    arm(2, 16'h0200, 16'h0202);
    push_acc(2, 16'h0200, 3'b000);
    push_acc(4, 16'h8000, 3'b000);
    push_acc(0, 16'h0100, 3'b000);
    push_acc(2, 16'h0201, 3'b000);
    push_acc(4, 16'h8001, 3'b010);
    push_acc(0, 16'h0101, 3'b000);
    req_rdy = 6'b111111;
    drain("R3 rotation drained");
    chk(cur_of(4) == 16'h8002, "R3 transmit requester finished", 32'(cur_of(4)), 32'h8002);
    req_rdy = '0;

    // bank boundary edge, R5
    arm(1, 16'h7fff, 16'h8001);
    push_acc(1, 16'h7fff, 3'b000);
    push_acc(1, 16'h8000, 3'b000);
    req_rdy = 6'b000010;
    drain("R5 boundary drained");
    req_rdy = '0;

    // slave defers while peer occupied, then N-1 pulse, R8 R7
    occ_len = 8'd4; is_master = 1'b0; occ_in = 1'b1;
    cyc(1);
    arm(0, 16'h0400, 16'h0401);
    req_rdy = 6'b000001;
    cyc(10);
    chk(cur_of(0) == 16'h0400, "R8 slave deferred", 32'(cur_of(0)), 32'h400);
    push_acc(0, 16'h0400, 3'b000);
    occ_in = 1'b0;
    @(negedge clk);
    chk(occ_out == 1'b0, "R8 slave silent in decision cycle", 32'(occ_out), 0);
    @(negedge clk);
    chk(occ_out && !mem_wr_n, "R8 slave occupied with strobe", 32'({occ_out, mem_wr_n}), 32'h2);
    begin
      int run = 0;
      while (occ_out && run < 20) begin
        run++;
        @(negedge clk);
      end
      chk(run == 3, "R7 slave occupied length", 32'(run), 3);
    end
    drain("R8 slave drained");

    // master defers too, and leads the strobe by one cycle, R8 R7
    is_master = 1'b1; occ_in = 1'b1;
    cyc(1);
    arm(0, 16'h0500, 16'h0501);
    cyc(6);
    chk(cur_of(0) == 16'h0500, "R8 master deferred", 32'(cur_of(0)), 32'h500);
    push_acc(0, 16'h0500, 3'b000);
    occ_in = 1'b0;
    @(negedge clk);
    chk(occ_out && mem_wr_n, "R8 master occupied before strobe", 32'({occ_out, mem_wr_n}), 32'h3);
    begin
      int run = 0;
      while (occ_out && run < 20) begin
        run++;
        @(negedge clk);
      end
      chk(run == 3, "R7 master occupied length", 32'(run), 3);
    end
    drain("R8 master drained");
    req_rdy = '0;
    is_master = 1'b0;

    // access spacing equals N, R7
    cyc(1);
    arm(2, 16'h0600, 16'h0603);
    push_acc(2, 16'h0600, 3'b000);
    push_acc(2, 16'h0601, 3'b000);
    push_acc(2, 16'h0602, 3'b000);
    req_rdy = 6'b000100;
    begin
      int w = 0;
      @(negedge clk);
      while (mem_wr_n && w < 50) begin
        w++;
        @(negedge clk);
      end
      for (int s = 0; s < 2; s++) begin
        int gap = 0;
        @(negedge clk);
        gap = 1;
        while (mem_wr_n && gap < 50) begin
          gap++;
          @(negedge clk);
        end
        chk(gap == 4, "R7 spacing between accesses", 32'(gap), 4);
      end
    end
    drain("R7 spacing drained");
    req_rdy = '0;

    // transmit channel 0 single word, R6
    occ_len = 8'd2;
    cyc(1);
    arm(3, 16'h0900, 16'h0901);
    push_acc(3, 16'h0900, 3'b001);
    req_rdy = 6'b001000;
    drain("R6 tx channel 0 drained");
    req_rdy = '0;
    @(negedge clk);
    chk(tx_done == 3'b000, "R6 tx_done low after", 32'(tx_done), 0);

    report();
  end
endmodule